// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the serial audio clocks for a converter that acts as clock master. From a crystal-derived master clock it makes a bit clock at 64 times the sample rate, a frame clock that marks the left and right halves of each sample period, and an auxiliary clock that runs either at the master clock rate or at half that rate. A two-bit ratio field tells the block whether the master clock is 512, 384 or 256 times the sample rate.

Configuration is a single 8-bit register written through a plain strobe-and-data port. Writes are taken only while the signal-processing reset and the converter reset inputs are both held low. While either reset is low the dividers stay cleared. A park bit forces both serial clocks to fixed levels, and the frame-clock level in that state depends on the selected data format. The half-rate flip-flop for the auxiliary clock is held at 0 while the init input is low, so its phase against the master clock is fixed when init is released.

Top module: `aclk_master_gen`

## Requirements
- R1: The ratio field, bits [7:6], selects the bit-clock period in master-clock cycles: 00 gives 8, 01 gives 6 and 11 gives 4. The bit clock is high for exactly half of each period. After the dividers start, it is low for the first half-period.
- R2: The frame clock starts low and toggles on the master-clock edge where the bit clock falls. It toggles every 32 bit-clock periods.
- R3: Ratio code 10 is a test code. With it selected and park clear, the bit clock and the frame clock both stay low.
- R4: A write strobe is accepted only when the signal-processing reset and the converter reset inputs are both low. Any other write leaves the register unchanged.
- R5: The register reads back as 00h after reset. Bit 0 always reads 0. Every other bit reads back as it was written.
- R6: With park, bit 2, set and bit 5 clear (justified format), the bit clock is low and the frame clock is high.
- R7: With park set and bit 5 set (I2S format), the bit clock is low and the frame clock is low.
- R8: With bit 1 clear, the auxiliary output follows the master clock.
- R9: With bit 1 set, the auxiliary output is the half-rate flip-flop. This takes effect from the master-clock edge that accepts the write.
- R10: While init is low, the half-rate flip-flop is held at 0. On each edge with init high it toggles.
- R11: The dividers advance only while both reset inputs are high. After the edge that samples either of them low, the bit clock, the frame clock and all divider counts return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_dsp_n | input | 1 | Signal-processing reset, active low |
| hold_codec_n | input | 1 | Converter reset, active low |
| init_n | input | 1 | Active-low phase alignment for the half-rate output |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| aux_o | output | 1 | Auxiliary clock |

## Verification
A slipped divider count shows up on the bit clock within one bit period of at most 8 master cycles. A wrong frame count only becomes visible at the next frame-clock toggle, up to 256 master cycles later, so each ratio is run over several whole frames. A wrongly accepted write, or a flipped half-rate flip-flop, appears on the read data or the auxiliary output at the next edge. Every output is compared against the reference model in both clock phases of every cycle.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [1:0] {
    RATIO_512  = 2'b00,
    RATIO_384  = 2'b01,
    RATIO_TEST = 2'b10,
    RATIO_256  = 2'b11
  } ratio_e;

  typedef struct packed {
    ratio_e     ratio;     // [7:6]
    logic       i2s;       // [5]
    logic [1:0] justify;   // [4:3]
    logic       park;      // [2]
    logic       aux_half;  // [1]
    logic       zero;      // [0]
  } cfg_t;

  // master cycles per sample period for each ratio code
  function automatic int unsigned fs_mult(ratio_e r);
    case (r)
      RATIO_384: return 384;
      RATIO_256: return 256;
      default:   return 512;
    endcase
  endfunction

endpackage

// File: rtl/aclk_cfg_reg.sv
module aclk_cfg_reg
  import aclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_dsp_n,
  input  logic       hold_codec_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output cfg_t       cfg_q
);

  logic accept;
  cfg_t cfg_d;

  always_comb begin
    accept = we & ~hold_dsp_n & ~hold_codec_n;
    cfg_d  = cfg_q;
    if (accept) begin
      cfg_d      = cfg_t'(wdata);
      cfg_d.zero = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cfg_t'(8'h00);
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/aclk_serial_div.sv
module aclk_serial_div
  import aclk_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  ratio_e ratio,
  output logic   bclk_q,
  output logic   fclk_q
);

  localparam int unsigned MAX_DIV = 512 / FRAME_BITS;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);
  localparam int unsigned HALF    = FRAME_BITS / 2;
  localparam int unsigned BIT_W   = $clog2(HALF);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, div_last, div_mid;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             bclk_d, fclk_d;
  logic             at_mid, at_last;

  always_comb begin
    div_last = CNT_W'(fs_mult(ratio) / FRAME_BITS - 1);
    div_mid  = CNT_W'(fs_mult(ratio) / FRAME_BITS / 2 - 1);
    at_mid   = (cnt_q == div_mid);
    at_last  = (cnt_q == div_last);
    cnt_d    = cnt_q;
    bclk_d   = bclk_q;
    bit_d    = bit_q;
    fclk_d   = fclk_q;
    if (!run) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
      bit_d  = '0;
      fclk_d = 1'b0;
    end else begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
      if (at_mid) bclk_d = 1'b1;
      if (at_last) begin
        bclk_d = 1'b0;
        if (bit_q == BIT_LAST) begin
          bit_d  = '0;
          fclk_d = ~fclk_q;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      bit_q  <= '0;
      fclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
      bit_q  <= bit_d;
      fclk_q <= fclk_d;
    end
  end

endmodule

// File: rtl/aclk_aux_div.sv
module aclk_aux_div (
  input  logic clk,
  input  logic rst_n,
  input  logic init_n,
  output logic half_q
);

  logic half_d;

  always_comb begin
    half_d = init_n ? ~half_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen
  import aclk_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_mst,
  input  logic       rst_n,
  input  logic       hold_dsp_n,
  input  logic       hold_codec_n,
  input  logic       init_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       aux_o
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  cfg_t                   cfg_q;
  logic                   run;
  logic                   bclk_q, fclk_q, half_q;
  logic                   test_mode;

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  aclk_cfg_reg i_cfg (
    .clk          (clk_mst),
    .rst_n        (rst_core_n),
    .hold_dsp_n   (hold_dsp_n),
    .hold_codec_n (hold_codec_n),
    .we           (cfg_we),
    .wdata        (cfg_wdata),
    .cfg_q        (cfg_q)
  );

  always_comb begin
    test_mode = (cfg_q.ratio == RATIO_TEST);
    run       = hold_dsp_n & hold_codec_n & ~cfg_q.park & ~test_mode;
  end

  aclk_serial_div #(.FRAME_BITS(FRAME_BITS)) i_sdiv (
    .clk    (clk_mst),
    .rst_n  (rst_core_n),
    .run    (run),
    .ratio  (cfg_q.ratio),
    .bclk_q (bclk_q),
    .fclk_q (fclk_q)
  );

  aclk_aux_div i_adiv (
    .clk    (clk_mst),
    .rst_n  (rst_core_n),
    .init_n (init_n),
    .half_q (half_q)
  );

  always_comb begin
    cfg_rdata = cfg_q;
    if (cfg_q.park) begin
      bclk_o = 1'b0;
      fclk_o = ~cfg_q.i2s;
    end else if (test_mode) begin
      bclk_o = 1'b0;
      fclk_o = 1'b0;
    end else begin
      bclk_o = bclk_q;
      fclk_o = fclk_q;
    end
    aux_o = cfg_q.aux_half ? half_q : clk_mst;
  end

endmodule

// File: rtl/aclk_master_gen_chk.sv
module aclk_master_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_dsp_n,
  input logic       hold_codec_n,
  input logic       init_n,
  input logic [7:0] cfg,
  input logic       bclk_o,
  input logic       fclk_o,
  input logic       aux_o
);

  // R6
  park_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2] && !cfg[5]) |-> (!bclk_o && fclk_o));

  // R7
  park_i2s_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2] && cfg[5]) |-> (!bclk_o && !fclk_o));

  // R3
  test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[7:6] == 2'b10 && !cfg[2]) |-> (!bclk_o && !fclk_o));

  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_dsp_n || hold_codec_n) |=> $stable(cfg));

  // R10
  aux_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1] && $past(cfg[1]) && $past(init_n)) |-> (aux_o != $past(aux_o)));

  // R10
  aux_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!init_n) && cfg[1]) |-> !aux_o);

  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!hold_dsp_n || !hold_codec_n) && !cfg[2]) |-> (!bclk_o && !fclk_o));

endmodule

bind aclk_master_gen aclk_master_gen_chk i_chk (
  .clk          (clk_mst),
  .rst_n        (rst_core_n),
  .hold_dsp_n   (hold_dsp_n),
  .hold_codec_n (hold_codec_n),
  .init_n       (init_n),
  .cfg          (cfg_q),
  .bclk_o       (bclk_o),
  .fclk_o       (fclk_o),
  .aux_o        (aux_o)
);

// File: tb/test_aclk_master_gen.sv
module test_aclk_master_gen;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, hold_dsp_n, hold_codec_n, init_n, cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       bclk_o, fclk_o, aux_o;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R5";
  bit    checking = 1'b0;
  bit    done = 1'b0;

  // reference model state
  logic [7:0] m_cfg;
  int         m_cnt, m_bit;
  logic       m_bclk, m_fclk, m_half, s1, s2;

  aclk_master_gen i_aclk_master_gen (
    .clk_mst(clk), .rst_n(rst_n), .hold_dsp_n(hold_dsp_n),
    .hold_codec_n(hold_codec_n), .init_n(init_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bclk_o(bclk_o),
    .fclk_o(fclk_o), .aux_o(aux_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic core_clear();
    m_cfg = 8'h00; m_cnt = 0; m_bit = 0;
    m_bclk = 1'b0; m_fclk = 1'b0; m_half = 1'b0;
  endtask

  always @(posedge clk) begin
    logic [7:0] old;
    bit         run;
    int         d;
    if (!rst_n) begin
      s1 = 1'b0; s2 = 1'b0; core_clear();
    end else if (!s2) begin
      s2 = s1; s1 = 1'b1; core_clear();
    end else begin
      old = m_cfg;
      if (cfg_we && !hold_dsp_n && !hold_codec_n) m_cfg = cfg_wdata & 8'hFE;
      run = hold_dsp_n && hold_codec_n && !old[2] && old[7:6] != 2'b10;
      if (!run) begin
        m_cnt = 0; m_bit = 0; m_bclk = 1'b0; m_fclk = 1'b0;
      end else begin
        d = (old[7:6] == 2'b00) ? 8 : (old[7:6] == 2'b01) ? 6 : 4;
        if (m_cnt == d/2 - 1) m_bclk = 1'b1;
        if (m_cnt == d - 1) begin
          m_bclk = 1'b0;
          if (m_bit == 31) begin m_bit = 0; m_fclk = ~m_fclk; end
          else m_bit++;
        end
        m_cnt = (m_cnt == d - 1) ? 0 : m_cnt + 1;
      end
      m_half = init_n ? ~m_half : 1'b0;
    end
  end

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare(bit hi);
    logic eb, ef, ea;
    eb = m_bclk; ef = m_fclk;
    if (m_cfg[2]) begin eb = 1'b0; ef = ~m_cfg[5]; end
    else if (m_cfg[7:6] == 2'b10) begin eb = 1'b0; ef = 1'b0; end
    ea = m_cfg[1] ? m_half : hi;
    check("bclk", {7'd0, bclk_o}, {7'd0, eb});
    check("fclk", {7'd0, fclk_o}, {7'd0, ef});
    check("aux", {7'd0, aux_o}, {7'd0, ea});
    check("rdata", cfg_rdata, m_cfg);
  endtask

  always @(posedge clk) if (checking) begin #1; compare(1'b1); end
  always @(negedge clk) if (checking) begin #1; compare(1'b0); end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #3; end
  endtask

  task automatic wr(logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(1); cfg_we = 1'b0;
  endtask

  task automatic hold(bit dsp_low, bit codec_low);
    hold_dsp_n = !dsp_low; hold_codec_n = !codec_low;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold_dsp_n = 1'b0; hold_codec_n = 1'b0;
    init_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    checking = 1'b1;
    cur_req = "R5"; tick(3);

    // R1 R2 R8: 512 fs, aux follows master clock
    cur_req = "R1 R2 R8";
    wr(8'h00); hold(0, 0); init_n = 1'b1; tick(1100);
    // R4: write while running is ignored
    cur_req = "R4"; wr(8'hFF); tick(20);
    // R11: dropping one reset clears the dividers
    cur_req = "R11"; hold(1, 0); tick(10); hold(0, 0); tick(30);
    hold(0, 1); tick(10);
    // R4: write with only one reset low is ignored
    cur_req = "R4"; wr(8'hC2); tick(5);
    hold(1, 1);
    cur_req = "R1 R2"; wr(8'h40); hold(0, 0); tick(800);
    hold(1, 1); wr(8'hC0); hold(0, 0); tick(600);
    // R3: test code
    hold(1, 1); cur_req = "R3"; wr(8'h80); hold(0, 0); tick(200);
    // R6 R7: parking
    hold(1, 1); cur_req = "R6"; wr(8'h04); hold(0, 0); tick(100);
    hold(1, 1); cur_req = "R7"; wr(8'h24); hold(0, 0); tick(100);
    // R9 R10: half-rate output with realignment
    hold(1, 1); cur_req = "R9"; wr(8'h02); hold(0, 0); tick(50);
    cur_req = "R10"; init_n = 1'b0; tick(3); init_n = 1'b1; tick(20);
    init_n = 1'b0; tick(1); init_n = 1'b1; tick(20);
    // R5: bit 0 reads 0
    hold(1, 1); cur_req = "R5"; wr(8'hFF); tick(5); wr(8'h19); tick(5);
    hold(0, 0); cur_req = "R1 R2 R9"; wr(8'hC2); tick(600);
    checking = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule